// File: doc/BRIEF.md
# Standby Entry and Release Controller

This block decides when a small 4-bit controller core goes into a low-power standby state and when it comes back out. Instruction decode hands it a one-cycle strobe for the standby instruction, together with that instruction's 4-bit operand. The operand picks the depth of standby, either stop or halt. It also picks which wake sources may end standby. The sources are a key-input line, a timer expiry and a spare external line. Each one is brought into the clock domain through a synchronizer.

The block owns a one-bit status flag, which other flag-setting instructions in the core also use. Whether the core enters standby depends on that flag and on the selected wake condition at the moment the strobe arrives. When the core does not enter, the flag is rewritten to show why. The block drives the standby indication, the stop indication that lets the clock-gating cells also stop the oscillator, a one-cycle resume pulse, and a resume-address select that tells the program counter to go to vector zero or to the next sequential address.

Top module: `stby_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, standby_o is 0, stop_o is 0, flag_o is 0 and resume_zero_o is 1, meaning resume at address zero.
- R2: The operand fields are as follows. Bit 3 selects stop mode when 1 and halt mode when 0. Bit 0 enables the key wake source, bit 1 the timer source and bit 2 the spare source. A strobe that sees flag 0 and a false selected wake condition enters standby at that clock edge. stop_o then equals bit 3 for the whole stay.
- R3: A strobe that sees flag 1 and a false selected wake condition does not enter standby, and it clears the flag to 0.
- R4: A strobe that sees flag 1 and a true selected wake condition does not enter standby, and the flag stays 1.
- R5: A strobe that sees flag 0 and a true selected wake condition does not enter standby, and it sets the flag to 1.
- R6: In standby, an enabled wake source that goes high ends standby on the third rising edge after the source changes (two synchronizer stages plus one state edge). At that edge the flag becomes 1, resume_zero_o becomes 0, meaning resume at the next address, and resume_o pulses high for exactly one cycle.
- R7: In standby, wake sources whose operand enable bit is 0 have no effect. standby_o stays 1.
- R8: A strobe with an all-zero wake mask still enters standby. Nothing but reset then ends it, and reset leaves standby_o 0 and resume_zero_o 1.
- R9: When there is no strobe and the core is not in standby, the flag write port (flag_we, flag_wd) sets the flag on the next edge. The port is ignored in a strobe cycle and while in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, including power-on |
| stby_strobe | input | 1 | One-cycle strobe from decode for the standby instruction |
| stby_operand | input | 4 | Operand: bit 3 mode select, bits 2..0 wake enables |
| wake_src | input | 3 | Asynchronous wake sources: bit 0 key, bit 1 timer, bit 2 spare |
| flag_we | input | 1 | Flag write enable from other instructions |
| flag_wd | input | 1 | Flag write value |
| flag_o | output | 1 | Shared status flag |
| standby_o | output | 1 | Standby active; gates the CPU clock |
| stop_o | output | 1 | Stop mode active; also gates the oscillator |
| resume_zero_o | output | 1 | 1: resume at address zero; 0: resume at next address |
| resume_o | output | 1 | One-cycle pulse when standby ends by a wake |

## Verification
The bench drives each of the four combinations of flag and wake condition at the strobe. A design that ignored the prior flag would go into standby when it should refuse. A design that left the flag alone on a refused attempt would keep the firmware out of standby without end. The bench also times the exit to the exact edge and checks that disabled sources cannot wake the core, which catches a wrong synchronizer depth or a stored mask that was never applied. Two further cases complete the set. In the first, flag writes arrive in a strobe cycle and during standby. In the second, an empty wake mask leaves reset as the only way out. These expose a design that gives the write port the wrong priority or that lets an empty mask refuse entry.

// File: rtl/stby_pkg.sv
package stby_pkg;

   // Operand layout: top bit is the mode, lower bits are wake enables.
   localparam int unsigned DEF_WAKE_N   = 3;
   localparam int unsigned DEF_SYNC_LEN = 2;

   typedef enum logic {
      MODE_HALT = 1'b0,
      MODE_STOP = 1'b1
   } stby_mode_e;

   typedef enum logic [1:0] {
      ACT_IDLE    = 2'd0,
      ACT_ENTER   = 2'd1,
      ACT_REFUSE  = 2'd2,
      ACT_WAKE    = 2'd3
   } stby_act_e;

endpackage

// File: rtl/stby_wake_sync.sv
module stby_wake_sync #(
   parameter int unsigned WIDTH = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stby_wake_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("stby_wake_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar gb;
   generate
      for (gb = 0; gb < WIDTH; gb++) begin : g_bit
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], async_i[gb]};
            end
         end
         assign sync_o[gb] = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/stby_wake_select.sv
module stby_wake_select #(
   parameter int unsigned WIDTH = 3
) (
   input  logic [WIDTH-1:0] enable_i,
   input  logic [WIDTH-1:0] source_i,
   output logic             hit_o
);

   logic [WIDTH-1:0] masked;

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_mask
         assign masked[gi] = enable_i[gi] & source_i[gi];
      end
   endgenerate

   assign hit_o = |masked;

endmodule

// File: rtl/stby_core_fsm.sv
module stby_core_fsm
   import stby_pkg::*;
#(
   parameter int unsigned WAKE_N = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  stby_mode_e        mode_i,
   input  logic [WAKE_N-1:0] mask_i,
   input  logic              hit_now_i,
   input  logic              hit_armed_i,
   input  logic              flag_we_i,
   input  logic              flag_wd_i,
   output logic [WAKE_N-1:0] armed_mask_o,
   output logic              standby_o,
   output logic              stop_o,
   output logic              flag_o,
   output logic              resume_zero_o,
   output logic              resume_o
);

   logic              standby_q;
   stby_mode_e        mode_q;
   logic [WAKE_N-1:0] mask_q;
   logic              flag_q;
   logic              rzero_q;
   logic              pulse_q;
   stby_act_e         act;

   // Classify the cycle: wake has priority in standby, strobe otherwise.
   always_comb begin
      act = ACT_IDLE;
      if (standby_q) begin
         if (hit_armed_i) act = ACT_WAKE;
      end else if (strobe_i) begin
         if (flag_q || hit_now_i) act = ACT_REFUSE;
         else                     act = ACT_ENTER;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         standby_q <= 1'b0;
         mode_q    <= MODE_HALT;
         mask_q    <= '0;
         flag_q    <= 1'b0;
         rzero_q   <= 1'b1;
         pulse_q   <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         unique case (act)
            ACT_ENTER: begin
               standby_q <= 1'b1;
               mode_q    <= mode_i;
               mask_q    <= mask_i;
            end
            ACT_REFUSE: begin
               // Flag reflects the wake condition seen at the refused strobe.
               flag_q <= hit_now_i;
            end
            ACT_WAKE: begin
               standby_q <= 1'b0;
               flag_q    <= 1'b1;
               rzero_q   <= 1'b0;
               pulse_q   <= 1'b1;
            end
            default: begin
               if (!standby_q && flag_we_i) flag_q <= flag_wd_i;
            end
         endcase
      end
   end

   assign armed_mask_o  = mask_q;
   assign standby_o     = standby_q;
   assign stop_o        = standby_q & (mode_q == MODE_STOP);
   assign flag_o        = flag_q;
   assign resume_zero_o = rzero_q;
   assign resume_o      = pulse_q;

   // R2: standby is only ever entered from a cleared flag.
   a_r2_entry_needs_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(standby_q) |-> !$past(flag_q));

   // R2: mode holds for the whole stay.
   a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_q && $past(standby_q)) |-> $stable(mode_q));

   // R3 / R4: strobe with flag set refuses and the flag follows the condition.
   a_r3_r4_refuse_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !standby_q && flag_q) |=> (!standby_q && (flag_q == $past(hit_now_i))));

   // R5: condition already true refuses and sets the flag.
   a_r5_refuse_cond_true: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !standby_q && hit_now_i) |=> (!standby_q && flag_q));

   // R6: a wake exit leaves the flag set and selects the next address.
   a_r6_exit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(standby_q) |-> (flag_q && !rzero_q && pulse_q));

   // R7 / R8: without an armed hit, standby holds.
   a_r7_hold_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_q && !hit_armed_i) |=> standby_q);

   // R9: flag is frozen while in standby without a wake.
   a_r9_flag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_q && !hit_armed_i) |=> $stable(flag_q));

   // R6: resume pulse lasts a single cycle.
   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
   import stby_pkg::*;
#(
   parameter int unsigned WAKE_N   = DEF_WAKE_N,
   parameter int unsigned SYNC_LEN = DEF_SYNC_LEN,
   localparam int unsigned OP_W    = WAKE_N + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stby_strobe,
   input  logic [OP_W-1:0]   stby_operand,
   input  logic [WAKE_N-1:0] wake_src,
   input  logic              flag_we,
   input  logic              flag_wd,
   output logic              flag_o,
   output logic              standby_o,
   output logic              stop_o,
   output logic              resume_zero_o,
   output logic              resume_o
);

   generate
      if (WAKE_N < 1 || WAKE_N > 8) begin : g_bad_wake_n
         $error("stby_ctrl: WAKE_N must be between 1 and 8");
      end
   endgenerate

   logic [WAKE_N-1:0] wake_sync;
   logic [WAKE_N-1:0] armed_mask;
   logic [WAKE_N-1:0] op_mask;
   stby_mode_e        op_mode;
   logic              hit_now;
   logic              hit_armed;

   assign op_mask = stby_operand[WAKE_N-1:0];
   assign op_mode = stby_mode_e'(stby_operand[OP_W-1]);

   stby_wake_sync #(.WIDTH(WAKE_N), .STAGES(SYNC_LEN)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (wake_src),
      .sync_o  (wake_sync)
   );

   stby_wake_select #(.WIDTH(WAKE_N)) u_sel_now (
      .enable_i (op_mask),
      .source_i (wake_sync),
      .hit_o    (hit_now)
   );

   stby_wake_select #(.WIDTH(WAKE_N)) u_sel_armed (
      .enable_i (armed_mask),
      .source_i (wake_sync),
      .hit_o    (hit_armed)
   );

   stby_core_fsm #(.WAKE_N(WAKE_N)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .strobe_i      (stby_strobe),
      .mode_i        (op_mode),
      .mask_i        (op_mask),
      .hit_now_i     (hit_now),
      .hit_armed_i   (hit_armed),
      .flag_we_i     (flag_we),
      .flag_wd_i     (flag_wd),
      .armed_mask_o  (armed_mask),
      .standby_o     (standby_o),
      .stop_o        (stop_o),
      .flag_o        (flag_o),
      .resume_zero_o (resume_zero_o),
      .resume_o      (resume_o)
   );

   // R2: stop indication implies standby.
   a_r2_stop_implies_standby: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> standby_o);

endmodule

// File: tb/stby_ctrl_test.sv
module stby_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stby_strobe = 1'b0;
   logic [3:0] stby_operand = '0;
   logic [2:0] wake_src = '0;
   logic       flag_we = 1'b0;
   logic       flag_wd = 1'b0;
   logic       flag_o, standby_o, stop_o, resume_zero_o, resume_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   stby_ctrl uut (
      .clk(clk), .rst_n(rst_n), .stby_strobe(stby_strobe),
      .stby_operand(stby_operand), .wake_src(wake_src),
      .flag_we(flag_we), .flag_wd(flag_wd), .flag_o(flag_o),
      .standby_o(standby_o), .stop_o(stop_o),
      .resume_zero_o(resume_zero_o), .resume_o(resume_o)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      stby_strobe = 1'b0; flag_we = 1'b0; wake_src = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write_flag(input logic v);
      flag_we = 1'b1; flag_wd = v;
      @(negedge clk);
      flag_we = 1'b0;
   endtask

   task automatic set_wake(input logic [2:0] v);
      wake_src = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic strobe(input logic [3:0] op);
      stby_strobe = 1'b1; stby_operand = op;
      @(negedge clk);
      stby_strobe = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "standby in reset", standby_o, 1'b0);
      check("R1", "resume_zero in reset", resume_zero_o, 1'b1);
      do_reset();
      check("R1", "standby after reset", standby_o, 1'b0);
      check("R1", "stop after reset", stop_o, 1'b0);
      check("R1", "flag after reset", flag_o, 1'b0);
      check("R1", "resume_zero after reset", resume_zero_o, 1'b1);
   endtask

   task automatic t_halt_wake_key();
      write_flag(1'b0);
      set_wake(3'b000);
      strobe(4'b0001);
      check("R2", "halt entered", standby_o, 1'b1);
      check("R2", "halt not stop", stop_o, 1'b0);
      set_wake(3'b110);
      check("R7", "disabled sources ignored", standby_o, 1'b1);
      write_flag(1'b1);
      check("R9", "flag write ignored in standby", flag_o, 1'b0);
      wake_src = 3'b111;
      @(negedge clk);
      @(negedge clk);
      check("R6", "still standby after two edges", standby_o, 1'b1);
      @(negedge clk);
      check("R6", "exit on third edge", standby_o, 1'b0);
      check("R6", "flag set on exit", flag_o, 1'b1);
      check("R6", "resume next address", resume_zero_o, 1'b0);
      check("R6", "resume pulse high", resume_o, 1'b1);
      @(negedge clk);
      check("R6", "resume pulse one cycle", resume_o, 1'b0);
      set_wake(3'b000);
   endtask

   task automatic t_stop_wake_timer();
      write_flag(1'b0);
      strobe(4'b1010);
      check("R2", "stop entered", standby_o, 1'b1);
      check("R2", "stop mode shown", stop_o, 1'b1);
      set_wake(3'b101);
      check("R7", "key and spare ignored with timer mask", standby_o, 1'b1);
      wake_src = 3'b010;
      repeat (3) @(negedge clk);
      check("R6", "timer wakes stop", standby_o, 1'b0);
      check("R6", "stop cleared after wake", stop_o, 1'b0);
      set_wake(3'b000);
   endtask

   task automatic t_refusals();
      // R3: flag 1, condition false
      write_flag(1'b1);
      strobe(4'b1001);
      check("R3", "no entry with flag set", standby_o, 1'b0);
      check("R3", "flag cleared", flag_o, 1'b0);
      // R4: flag 1, condition true
      set_wake(3'b001);
      write_flag(1'b1);
      strobe(4'b0001);
      check("R4", "no entry with flag and cond", standby_o, 1'b0);
      check("R4", "flag kept", flag_o, 1'b1);
      // R5: flag 0, condition true
      write_flag(1'b0);
      strobe(4'b0001);
      check("R5", "no entry with cond true", standby_o, 1'b0);
      check("R5", "flag set", flag_o, 1'b1);
      set_wake(3'b000);
   endtask

   task automatic t_flag_port();
      write_flag(1'b1);
      check("R9", "flag write sets", flag_o, 1'b1);
      write_flag(1'b0);
      check("R9", "flag write clears", flag_o, 1'b0);
      // Write of 1 in the strobe cycle is ignored; entry proceeds.
      flag_we = 1'b1; flag_wd = 1'b1;
      strobe(4'b0100);
      flag_we = 1'b0;
      check("R9", "strobe beats flag write", flag_o, 1'b0);
      check("R9", "entry despite flag write", standby_o, 1'b1);
      wake_src = 3'b100;
      repeat (3) @(negedge clk);
      check("R9", "spare wakes after", standby_o, 1'b0);
      set_wake(3'b000);
   endtask

   task automatic t_zero_mask();
      write_flag(1'b0);
      strobe(4'b1000);
      check("R8", "empty mask enters", standby_o, 1'b1);
      set_wake(3'b111);
      repeat (6) @(negedge clk);
      check("R8", "empty mask never wakes", standby_o, 1'b1);
      do_reset();
      check("R8", "reset ends standby", standby_o, 1'b0);
      check("R8", "reset resumes at zero", resume_zero_o, 1'b1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_halt_wake_key();
      t_stop_wake_timer();
      t_refusals();
      t_flag_port();
      t_zero_mask();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule